// File: doc/BRIEF.md
# Bridge Fault Supervisor with Auto-Retry

This block is the protection supervisor for a pair of H-bridges. It takes digital flags from the analog detectors: an overcurrent flag per bridge, one die overtemperature flag, a supply undervoltage flag, a sleep request and a flag that says the internal supplies are stable. From these it produces one enable-permit per bridge, a global logic reset for the step sequencer, an active-low fault output that maps onto an open-drain pad, and a ready flag.

An overcurrent flag has to stay high for a deglitch window before its bridge is turned off. The window has two lengths, and a low-current input picks the shorter one. The bridge then stays off for a fixed retry period and is released on its own. If the flag is still high, the shutdown and retry repeat. The other bridge is not affected. Overtemperature turns off both bridges until the flag clears. Undervoltage and sleep both hold all logic in reset. Undervoltage shows on the fault output and sleep does not, because sleep ignores every other input. When either condition ends, the block holds the fault output low in a wake phase until the supplies report stable. The control-mode selection is captured while the block is not running and is frozen while it runs.

Top module: `bridge_fault_sup`

## Requirements
- R1: The reset input is synchronous and active high. It puts the block in the wake phase: `ready_o`=0, `logic_rst_o`=1, `fault_n_o`=0, both bridge enables 0 and `mode_o`=0.
- R2: In the wake phase `fault_n_o` stays 0 and the bridges stay off. The first clock edge that samples `supply_ok_i`=1 moves the block to run: `ready_o`=1, `logic_rst_o`=0, `fault_n_o`=1. The edge that leaves hold always lands in wake, even when supplies are already stable.
- R3: While running and not shut down, a bridge turns off after its overcurrent flag has been sampled high on N consecutive edges. N is DGL_HI_CYC when `ocp_lowref_i`=0 and DGL_LO_CYC when it is 1. A low sample clears the count.
- R4: An overcurrent shutdown turns off only its own bridge. The other bridge enable is unaffected.
- R5: A shut-down bridge stays off for exactly RETRY_CYC edges and is then re-enabled. Its overcurrent flag is ignored during that time and counting restarts after release, so a flag that stays high repeats the cycle.
- R6: `fault_n_o` is 0 exactly when at least one of these holds: a bridge is in overcurrent shutdown, overtemperature is latched, undervoltage is latched, or the block is in the wake phase.
- R7: While running, an overtemperature flag sampled at an edge turns off both bridges and pulls `fault_n_o` low after that edge. The first edge that samples it clear restores them.
- R8: Undervoltage without sleep puts the block in hold on the next edge: `logic_rst_o`=1, `ready_o`=0, `fault_n_o`=0, both bridges off and all overcurrent state cleared. When the flag clears, the block enters wake.
- R9: A sleep request puts the block in hold with `fault_n_o`=1, `logic_rst_o`=1 and both bridges off, whatever the other flags are. Leaving sleep enters wake.
- R10: `mode_o` loads `mode_sel_i` on every edge at which the block is not running, including the edge that enters run. It holds its value while running.
- R11: The status outputs show their sources directly: `ocp_stat_o[i]`=1 while bridge i is shut down, `ot_stat_o` is latched overtemperature, `uv_stat_o` is latched undervoltage and `wake_stat_o` is the wake phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset (power-up) |
| ocp_i | input | NB_BRIDGE | Per-bridge overcurrent flag |
| ocp_lowref_i | input | 1 | Low current setting, selects the short deglitch |
| otemp_i | input | 1 | Overtemperature flag |
| uvlo_i | input | 1 | Supply undervoltage flag |
| sleep_i | input | 1 | Sleep request, active high |
| supply_ok_i | input | 1 | Internal supplies stable |
| mode_sel_i | input | 1 | Control-mode selection to capture |
| bridge_en_o | output | NB_BRIDGE | Per-bridge enable permit |
| logic_rst_o | output | 1 | Global logic reset for the sequencer |
| fault_n_o | output | 1 | Active-low fault indication |
| ready_o | output | 1 | Block is in the run phase |
| mode_o | output | 1 | Captured control mode |
| ocp_stat_o | output | NB_BRIDGE | Per-bridge overcurrent shutdown status |
| ot_stat_o | output | 1 | Latched overtemperature status |
| uv_stat_o | output | 1 | Latched undervoltage status |
| wake_stat_o | output | 1 | Wake phase status |

## Verification
The bench goes after several corner cases. One is an overcurrent pulse that drops one cycle short of the deglitch window; a counter that does not clear on the drop would shut the bridge later. Another is a flag held high through the retry period: a design that counted during shutdown would re-trip right at release instead of a full window later, and one that disabled both bridges would show up on the untouched bridge. The bench also enters sleep while overtemperature is asserted and checks that the fault output stays released, and it checks that the captured mode ignores changes while running but picks up the value present when sleep is left.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  typedef enum logic [1:0] {
    PH_HOLD = 2'd0,
    PH_WAKE = 2'd1,
    PH_RUN  = 2'd2
  } fsup_phase_e;
endpackage

// File: rtl/fsup_phase_ctl.sv
module fsup_phase_ctl
  import fsup_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_i,
  input  logic        sleep_i,
  input  logic        uvlo_i,
  input  logic        supply_ok_i,
  input  logic        mode_sel_i,
  output fsup_phase_e phase_o,
  output logic        uv_o,
  output logic        mode_o
);
  fsup_phase_e phase_q, phase_d;
  logic        uv_q, mode_q;
  logic        hold;

  assign hold = sleep_i | uvlo_i;

  always_comb begin
    phase_d = phase_q;
    if (hold)                                  phase_d = PH_HOLD;
    else if (phase_q == PH_HOLD)               phase_d = PH_WAKE;
    else if (phase_q == PH_WAKE && supply_ok_i) phase_d = PH_RUN;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      phase_q <= PH_WAKE;
      uv_q    <= 1'b0;
      mode_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      uv_q    <= uvlo_i & ~sleep_i;
      if (phase_q != PH_RUN) mode_q <= mode_sel_i;
    end
  end

  assign phase_o = phase_q;
  assign uv_o    = uv_q;
  assign mode_o  = mode_q;

  // R2
  wake_to_run_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (phase_q == PH_WAKE && supply_ok_i && !sleep_i && !uvlo_i) |=> (phase_q == PH_RUN));

  // R10
  mode_frozen_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (phase_q == PH_RUN && $past(phase_q) == PH_RUN) |-> $stable(mode_q));
endmodule

// File: rtl/fsup_ocp_chan.sv
module fsup_ocp_chan #(
  parameter int DGL_HI_CYC = 400,
  parameter int DGL_LO_CYC = 275,
  parameter int RETRY_CYC  = 300000,
  localparam int MAXC = (RETRY_CYC > DGL_HI_CYC) ?
                        ((RETRY_CYC > DGL_LO_CYC) ? RETRY_CYC : DGL_LO_CYC) :
                        ((DGL_HI_CYC > DGL_LO_CYC) ? DGL_HI_CYC : DGL_LO_CYC),
  localparam int CW   = $clog2(MAXC + 1)
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic clr_i,
  input  logic ocp_i,
  input  logic lowref_i,
  output logic shut_o
);
  localparam logic [CW-1:0] HI_LAST    = CW'(DGL_HI_CYC - 1);
  localparam logic [CW-1:0] LO_LAST    = CW'(DGL_LO_CYC - 1);
  localparam logic [CW-1:0] RETRY_LAST = CW'(RETRY_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          shut_q;
  logic [CW-1:0] dgl_last;

  assign dgl_last = lowref_i ? LO_LAST : HI_LAST;

  always_ff @(posedge clk_i) begin
    if (rst_i || clr_i) begin
      cnt_q  <= '0;
      shut_q <= 1'b0;
    end else if (shut_q) begin
      if (cnt_q == RETRY_LAST) begin
        shut_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (ocp_i) begin
      if (cnt_q >= dgl_last) begin
        shut_q <= 1'b1;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign shut_o = shut_q;

  // R3
  shut_needs_flag_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(shut_q) |-> $past(ocp_i));

  // R5
  retry_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (shut_q && cnt_q != RETRY_LAST && !clr_i) |=> shut_q);
endmodule

// File: rtl/bridge_fault_sup.sv
module bridge_fault_sup
  import fsup_pkg::*;
#(
  parameter int NB_BRIDGE  = 2,
  parameter int DGL_HI_CYC = 400,
  parameter int DGL_LO_CYC = 275,
  parameter int RETRY_CYC  = 300000
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic [NB_BRIDGE-1:0] ocp_i,
  input  logic                 ocp_lowref_i,
  input  logic                 otemp_i,
  input  logic                 uvlo_i,
  input  logic                 sleep_i,
  input  logic                 supply_ok_i,
  input  logic                 mode_sel_i,
  output logic [NB_BRIDGE-1:0] bridge_en_o,
  output logic                 logic_rst_o,
  output logic                 fault_n_o,
  output logic                 ready_o,
  output logic                 mode_o,
  output logic [NB_BRIDGE-1:0] ocp_stat_o,
  output logic                 ot_stat_o,
  output logic                 uv_stat_o,
  output logic                 wake_stat_o
);
  fsup_phase_e          phase;
  logic                 uv_q, ot_q, run, hold, chan_clr;
  logic [NB_BRIDGE-1:0] shut;

  assign hold     = sleep_i | uvlo_i;
  assign run      = (phase == PH_RUN);
  assign chan_clr = ~run | hold;

  fsup_phase_ctl u_phase (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .sleep_i     (sleep_i),
    .uvlo_i      (uvlo_i),
    .supply_ok_i (supply_ok_i),
    .mode_sel_i  (mode_sel_i),
    .phase_o     (phase),
    .uv_o        (uv_q),
    .mode_o      (mode_o)
  );

  for (genvar b = 0; b < NB_BRIDGE; b++) begin : g_chan
    fsup_ocp_chan #(
      .DGL_HI_CYC (DGL_HI_CYC),
      .DGL_LO_CYC (DGL_LO_CYC),
      .RETRY_CYC  (RETRY_CYC)
    ) u_chan (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .clr_i    (chan_clr),
      .ocp_i    (ocp_i[b]),
      .lowref_i (ocp_lowref_i),
      .shut_o   (shut[b])
    );
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) ot_q <= 1'b0;
    else       ot_q <= run & otemp_i & ~hold;
  end

  // outputs are decoded only from flops, no input reaches them combinationally
  always_comb begin
    for (int b = 0; b < NB_BRIDGE; b++)
      bridge_en_o[b] = run & ~ot_q & ~shut[b];
  end
  assign ready_o     = run;
  assign logic_rst_o = ~run;
  assign fault_n_o   = ~(uv_q | ot_q | (|shut) | (phase == PH_WAKE));
  assign ocp_stat_o  = shut;
  assign ot_stat_o   = ot_q;
  assign uv_stat_o   = uv_q;
  assign wake_stat_o = (phase == PH_WAKE);

  // R9
  sleep_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    sleep_i |=> (fault_n_o && logic_rst_o && bridge_en_o == '0));

  // R8
  uv_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (uvlo_i && !sleep_i) |=> (!ready_o && !fault_n_o && ocp_stat_o == '0));

  // R7
  ot_off_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (ready_o && otemp_i && !sleep_i && !uvlo_i) |=> (bridge_en_o == '0 && !fault_n_o));

  // R4
  en_needs_ready_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (bridge_en_o != '0) |-> ready_o);
endmodule

// File: tb/sim_bridge_fault_sup.sv
module sim_bridge_fault_sup;
  localparam int NB  = 2;
  localparam int DHI = 8;
  localparam int DLO = 5;
  localparam int RTY = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NB-1:0] ocp = '0;
  logic lowref = 1'b0, otemp = 1'b0, uvlo = 1'b0, sleep = 1'b0;
  logic supok = 1'b0, msel = 1'b1;
  logic [NB-1:0] en, ostat;
  logic lrst, fn, rdy, mode, ots, uvs, wks;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  bridge_fault_sup #(.NB_BRIDGE(NB), .DGL_HI_CYC(DHI), .DGL_LO_CYC(DLO), .RETRY_CYC(RTY)) u0 (
    .clk_i(clk), .rst_i(rst), .ocp_i(ocp), .ocp_lowref_i(lowref), .otemp_i(otemp),
    .uvlo_i(uvlo), .sleep_i(sleep), .supply_ok_i(supok), .mode_sel_i(msel),
    .bridge_en_o(en), .logic_rst_o(lrst), .fault_n_o(fn), .ready_o(rdy), .mode_o(mode),
    .ocp_stat_o(ostat), .ot_stat_o(ots), .uv_stat_o(uvs), .wake_stat_o(wks));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 hold, 1 wake, 2 run
  int m_ph = 1;
  int m_cnt[NB];
  bit m_sh[NB];
  bit m_ot, m_uv, m_mode;
  bit m_live = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 1; m_ot = 0; m_uv = 0; m_mode = 0;
      foreach (m_cnt[b]) begin m_cnt[b] = 0; m_sh[b] = 0; end
    end else begin
      bit was_run;
      bit hold;
      int lim;
      was_run = (m_ph == 2);
      hold    = sleep || uvlo;
      lim     = lowref ? DLO : DHI;
      foreach (m_cnt[b]) begin
        if (!was_run || hold) begin m_cnt[b] = 0; m_sh[b] = 0; end
        else if (m_sh[b]) begin
          if (m_cnt[b] == RTY - 1) begin m_sh[b] = 0; m_cnt[b] = 0; end
          else m_cnt[b]++;
        end else if (ocp[b]) begin
          if (m_cnt[b] >= lim - 1) begin m_sh[b] = 1; m_cnt[b] = 0; end
          else m_cnt[b]++;
        end else m_cnt[b] = 0;
      end
      m_ot = was_run && otemp && !hold;
      m_uv = uvlo && !sleep;
      if (!was_run) m_mode = msel;
      if (hold) m_ph = 0;
      else if (m_ph == 0) m_ph = 1;
      else if (m_ph == 1 && supok) m_ph = 2;
    end
    m_live = 1;
  end

  always @(posedge clk) begin
    #1;
    if (m_live) begin
      bit any_sh;
      any_sh = 0;
      foreach (m_sh[b]) begin
        any_sh |= m_sh[b];
        chk("R3 R4 R5 bridge_en", int'(en[b]), int'(m_ph == 2 && !m_ot && !m_sh[b]));
        chk("R11 ocp_stat", int'(ostat[b]), int'(m_sh[b]));
      end
      chk("R6 fault_n", int'(fn), int'(!(m_uv || m_ot || any_sh || m_ph == 1)));
      chk("R2 ready", int'(rdy), int'(m_ph == 2));
      chk("R8 logic_rst", int'(lrst), int'(m_ph != 2));
      chk("R10 mode", int'(mode), int'(m_mode));
      chk("R11 ot_stat", int'(ots), int'(m_ot));
      chk("R11 uv_stat", int'(uvs), int'(m_uv));
      chk("R11 wake_stat", int'(wks), int'(m_ph == 1));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cyc(3);
    chk("R1 ready", int'(rdy), 0);
    chk("R1 logic_rst", int'(lrst), 1);
    chk("R1 fault_n", int'(fn), 0);
    chk("R1 bridge_en", int'(en), 0);
    chk("R1 mode", int'(mode), 0);
    rst = 1'b0;
    cyc(2);
    chk("R2 wake holds fault", int'(fn), 0);
    supok = 1'b1;
    cyc(1);
    chk("R2 ready", int'(rdy), 1);
    chk("R2 fault_n", int'(fn), 1);
    msel = 1'b0;
    cyc(3);
    chk("R10 mode frozen", int'(mode), 1);
    // deglitch: short pulse then full window
    ocp[0] = 1'b1;
    cyc(7);
    chk("R3 short pulse", int'(en[0]), 1);
    ocp[0] = 1'b0;
    cyc(1);
    ocp[0] = 1'b1;
    cyc(7);
    chk("R3 count cleared", int'(en[0]), 1);
    cyc(1);
    chk("R3 trip", int'(en[0]), 0);
    chk("R4 other bridge", int'(en[1]), 1);
    chk("R6 fault on ocp", int'(fn), 0);
    chk("R11 ocp_stat", int'(ostat), 1);
    cyc(RTY);
    chk("R5 release", int'(en[0]), 1);
    cyc(7);
    chk("R5 recount", int'(en[0]), 1);
    cyc(1);
    chk("R5 repeat trip", int'(en[0]), 0);
    ocp[0] = 1'b0;
    cyc(RTY + 1);
    chk("R5 back on", int'(en[0]), 1);
    // low-current deglitch
    lowref = 1'b1;
    ocp[1] = 1'b1;
    cyc(DLO - 1);
    chk("R3 low window not yet", int'(en[1]), 1);
    cyc(1);
    chk("R3 low window trip", int'(en[1]), 0);
    ocp[1] = 1'b0;
    lowref = 1'b0;
    cyc(RTY + 1);
    // overtemperature
    otemp = 1'b1;
    cyc(1);
    chk("R7 bridges off", int'(en), 0);
    chk("R7 fault", int'(fn), 0);
    otemp = 1'b0;
    cyc(1);
    chk("R7 resume", int'(en), 3);
    // undervoltage
    uvlo = 1'b1;
    supok = 1'b0;
    ocp[0] = 1'b1;
    cyc(1);
    chk("R8 logic_rst", int'(lrst), 1);
    chk("R8 fault", int'(fn), 0);
    chk("R8 ready", int'(rdy), 0);
    cyc(DHI + 2);
    chk("R8 ocp ignored", int'(ostat), 0);
    ocp[0] = 1'b0;
    uvlo = 1'b0;
    cyc(1);
    chk("R8 wake after uv", int'(wks), 1);
    chk("R8 wake fault", int'(fn), 0);
    supok = 1'b1;
    cyc(1);
    chk("R8 run again", int'(en), 3);
    // sleep dominates
    sleep = 1'b1;
    otemp = 1'b1;
    uvlo = 1'b1;
    msel = 1'b1;
    cyc(1);
    chk("R9 fault released", int'(fn), 1);
    chk("R9 logic_rst", int'(lrst), 1);
    chk("R9 bridges off", int'(en), 0);
    cyc(3);
    chk("R9 still released", int'(fn), 1);
    sleep = 1'b0;
    otemp = 1'b0;
    uvlo = 1'b0;
    cyc(1);
    chk("R9 wake after sleep", int'(fn), 0);
    cyc(1);
    chk("R9 running", int'(rdy), 1);
    chk("R10 mode recaptured", int'(mode), 1);
    cyc(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #40000;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule